// File: doc/BRIEF.md
# Eight-Channel Backlight Dimming PWM

This block produces eight logic-level pulse-width outputs that set the brightness of eight lamp inverter channels. Each channel owns an 8-bit brightness code. The code maps onto a duty cycle that starts at a fixed floor of about 4% of the frame and reaches a continuous high level at the top code. All channels share one frame counter, so every channel's pulse starts at the same frame boundary.

The frame length has two sources. With no sync signal it free-runs at `FREE_PERIOD` clock cycles. When an external sync signal is present, the block measures the time between its rising edges. The block follows that period once two measurements in a row fall inside the lock window `[MIN_PERIOD, MAX_PERIOD]`. It returns to free-running when a measurement falls outside the window or when no edge arrives for `MAX_PERIOD` cycles. Only the frame rate follows the sync signal. The frame phase is not aligned to it.

Software sets the brightness codes, a master enable and a per-channel enable mask through a one-beat valid/ready write port. `wr_ready` is always high, so the port never applies back-pressure, and a beat is taken on every cycle that `wr_valid` is high.

Top module: `bl_dim_pwm`

## Requirements
- R1: Each of the eight outputs `pwm_out[i]` depends only on its own brightness code and mask bit plus the shared frame, master enable and sync state.
- R2: For a code below 0xFF, the output is high for F + floor(code·(P−F)/255) cycles of each P-cycle frame, with F = floor(P·4/100). The high cycles come first in the frame, so code 0x00 gives F cycles and code 0x7F gives 207 of 400.
- R3: Code 0xFF holds the output high for every cycle of the frame.
- R4: With no sync edges, every frame lasts `FREE_PERIOD` cycles (default 400).
- R5: After reset, `sync_in` passes through two synchronizing flops and its rising edges are detected. Once two consecutive edge-to-edge periods both lie within [`MIN_PERIOD`, `MAX_PERIOD`] (300..500), frames take the latest measured period, starting at the next frame boundary.
- R6: A measured period outside the window, or `MAX_PERIOD` cycles without an edge, drops the lock, and frames return to `FREE_PERIOD` from the next boundary.
- R7: Writing address 0x2B sets the master enable from data bit 0. While it is 0, all outputs are low, starting from the cycle after the write.
- R8: Writing address 0x2C sets the channel mask, where data bit i enables channel i. A disabled channel is low from the cycle after the write.
- R9: Writing address 0x00+i sets the brightness code of channel i. A new code first shapes the pulse of the next frame, and the current frame keeps the old width.
- R10: `wr_ready` is always 1. Writes to any other address leave every output unchanged.
- R11: Reset clears all codes, the master enable and the mask, so all outputs are low. The first frame begins on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat ready, always high |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| sync_in | input | 1 | External frame-rate sync, asynchronous |
| pwm_out | output | 8 | Dimming PWM outputs, one per channel |

## Verification
Enable and mask writes change the outputs in the first cycle after the accepting edge. A code write changes nothing until the next frame boundary. A sync edge passes through three registers before it is measured, and a new lock changes the frame length only at the following frame boundary. The bench's behavioural model steps the same register counts on every rising edge. The bench compares the model with every output at each falling edge, so all of these latencies are checked exactly. Directed checks count the high cycles and frame lengths only after locating a frame start and letting the sync input settle for several periods.

// File: rtl/bl_dim_pkg.sv
package bl_dim_pkg;
  localparam int unsigned PCT_SCALE = 100;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return $clog2(max_val + 2);
  endfunction
endpackage

// File: rtl/bl_dim_regs.sv
module bl_dim_regs #(
  parameter int NUM_CH      = 8,
  parameter int CODE_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int CODE_BASE   = 'h00,
  parameter int MASTER_ADDR = 'h2B,
  parameter int MASK_ADDR   = 'h2C
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic                     master_en,
  output logic [NUM_CH-1:0]        ch_mask,
  output logic [NUM_CH*CODE_W-1:0] codes
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_en <= 1'b0;
      ch_mask   <= '0;
    end else if (wr_valid) begin
      if (wr_addr == ADDR_W'(MASTER_ADDR)) master_en <= wr_data[0];
      if (wr_addr == ADDR_W'(MASK_ADDR))   ch_mask   <= wr_data[NUM_CH-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_code
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= '0;
      else if (wr_valid && wr_addr == ADDR_W'(CODE_BASE + g))
        code_q <= wr_data[CODE_W-1:0];
    end
    assign codes[g*CODE_W +: CODE_W] = code_q;
  end
endmodule

// File: rtl/bl_dim_sync.sv
module bl_dim_sync #(
  parameter int MIN_PERIOD = 300,
  parameter int MAX_PERIOD = 500,
  parameter int PER_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  output logic             rise,
  output logic             locked,
  output logic [PER_W-1:0] lock_per
);
  logic             s1, s2, s3;
  logic [PER_W-1:0] meas;
  logic             prev_ok;
  logic [PER_W-1:0] cand;
  logic             in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= sync_in; s2 <= s1; s3 <= s2;
    end
  end

  assign rise   = s2 & ~s3;
  assign cand   = meas + 1'b1;
  assign in_win = (cand >= PER_W'(MIN_PERIOD)) && (cand <= PER_W'(MAX_PERIOD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas     <= PER_W'(MAX_PERIOD);
      prev_ok  <= 1'b0;
      locked   <= 1'b0;
      lock_per <= PER_W'(MAX_PERIOD);
    end else if (rise) begin
      meas <= '0;
      if (in_win) begin
        prev_ok <= 1'b1;
        if (prev_ok) begin
          locked   <= 1'b1;
          lock_per <= cand;
        end
      end else begin
        prev_ok <= 1'b0;
        locked  <= 1'b0;
      end
    end else if (meas == PER_W'(MAX_PERIOD)) begin
      prev_ok <= 1'b0;
      locked  <= 1'b0;
    end else begin
      meas <= meas + 1'b1;
    end
  end
endmodule

// File: rtl/bl_dim_frame.sv
module bl_dim_frame
  import bl_dim_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int CODE_W      = 8,
  parameter int PER_W       = 9,
  parameter int FREE_PERIOD = 400,
  parameter int FLOOR_PCT   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     master_en,
  input  logic [NUM_CH-1:0]        ch_mask,
  input  logic [NUM_CH*CODE_W-1:0] codes,
  input  logic                     locked,
  input  logic [PER_W-1:0]         lock_per,
  output logic [NUM_CH-1:0]        pwm_out,
  output logic [PER_W-1:0]         fcnt,
  output logic [PER_W-1:0]         per_lat,
  output logic [NUM_CH*PER_W-1:0]  thr_flat
);
  localparam int PROD_W   = PER_W + CODE_W;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  logic [PER_W-1:0] next_per, floor_t, span;
  logic             wrap;

  assign next_per = locked ? lock_per : PER_W'(FREE_PERIOD);
  assign floor_t  = PER_W'((32'(next_per) * FLOOR_PCT) / PCT_SCALE);
  assign span     = next_per - floor_t;
  assign wrap     = (fcnt == per_lat - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt    <= PER_W'(FREE_PERIOD - 1);
      per_lat <= PER_W'(FREE_PERIOD);
    end else if (wrap) begin
      fcnt    <= '0;
      per_lat <= next_per;
    end else begin
      fcnt <= fcnt + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [CODE_W-1:0] code_i;
    logic [PROD_W-1:0] scaled;
    logic [PER_W-1:0]  thr_q;
    logic              full_q;

    assign code_i = codes[g*CODE_W +: CODE_W];
    assign scaled = (PROD_W'(code_i) * PROD_W'(span)) / PROD_W'(CODE_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_q  <= '0;
        full_q <= 1'b0;
      end else if (wrap) begin
        thr_q  <= floor_t + PER_W'(scaled);
        full_q <= &code_i;
      end
    end

    assign thr_flat[g*PER_W +: PER_W] = thr_q;
    assign pwm_out[g] = master_en & ch_mask[g] & (full_q | (fcnt < thr_q));
  end
endmodule

// File: rtl/bl_dim_pwm.sv
module bl_dim_pwm
  import bl_dim_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int CODE_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int FREE_PERIOD = 400,
  parameter int MIN_PERIOD  = 300,
  parameter int MAX_PERIOD  = 500,
  parameter int FLOOR_PCT   = 4,
  parameter int CODE_BASE   = 'h00,
  parameter int MASTER_ADDR = 'h2B,
  parameter int MASK_ADDR   = 'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sync_in,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int PER_W = cnt_width(MAX_PERIOD);

  logic                     master_en;
  logic [NUM_CH-1:0]        ch_mask;
  logic [NUM_CH*CODE_W-1:0] codes;
  logic                     rise, locked;
  logic [PER_W-1:0]         lock_per, fcnt, per_lat;
  logic [NUM_CH*PER_W-1:0]  thr_flat;

  assign wr_ready = 1'b1;

  bl_dim_regs #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CODE_BASE(CODE_BASE), .MASTER_ADDR(MASTER_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .master_en(master_en), .ch_mask(ch_mask), .codes(codes)
  );

  bl_dim_sync #(
    .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD), .PER_W(PER_W)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .rise(rise),
    .locked(locked), .lock_per(lock_per)
  );

  bl_dim_frame #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .PER_W(PER_W),
    .FREE_PERIOD(FREE_PERIOD), .FLOOR_PCT(FLOOR_PCT)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .ch_mask(ch_mask),
    .codes(codes), .locked(locked), .lock_per(lock_per), .pwm_out(pwm_out),
    .fcnt(fcnt), .per_lat(per_lat), .thr_flat(thr_flat)
  );
endmodule

// File: rtl/bl_dim_pwm_chk.sv
module bl_dim_pwm_chk #(
  parameter int NUM_CH      = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PER_W       = 9,
  parameter int MIN_PERIOD  = 300,
  parameter int MAX_PERIOD  = 500,
  parameter int MASTER_ADDR = 'h2B,
  parameter int MASK_ADDR   = 'h2C,
  parameter int THR_W       = 72
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [NUM_CH-1:0] pwm_out,
  input logic              master_en,
  input logic [NUM_CH-1:0] ch_mask,
  input logic [PER_W-1:0]  fcnt,
  input logic [PER_W-1:0]  per_lat,
  input logic [THR_W-1:0]  thr_flat,
  input logic              locked,
  input logic              rise
);
  p_master_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == ADDR_W'(MASTER_ADDR) && !wr_data[0]) |=> (pwm_out == '0));

  p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == ADDR_W'(MASK_ADDR)) |=>
      ((pwm_out & ~$past(wr_data[NUM_CH-1:0])) == '0));

  p_floor_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt == '0) |-> ((pwm_out | ~(ch_mask & {NUM_CH{master_en}})) == '1));

  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt != '0) |-> $stable(thr_flat));

  p_period_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (per_lat >= PER_W'(MIN_PERIOD)) && (per_lat <= PER_W'(MAX_PERIOD)));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt < per_lat);

  p_lock_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(rise));
endmodule

bind bl_dim_pwm bl_dim_pwm_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PER_W(PER_W),
  .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD),
  .MASTER_ADDR(MASTER_ADDR), .MASK_ADDR(MASK_ADDR), .THR_W(NUM_CH*PER_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .pwm_out(pwm_out), .master_en(master_en),
  .ch_mask(ch_mask), .fcnt(fcnt), .per_lat(per_lat), .thr_flat(thr_flat),
  .locked(locked), .rise(rise)
);

// File: tb/sim_bl_dim_pwm.sv
`timescale 1ns/1ps
module sim_bl_dim_pwm;
  localparam int NCH  = 8;
  localparam int FREE = 400;
  localparam int PMIN = 300;
  localparam int PMAX = 500;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sync_in = 1'b0;
  logic [7:0] pwm_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int sync_per = 0;
  int sync_cnt = 0;
  bit cmp_on = 1'b0;
  int hc [NCH];

  always #4 clk = ~clk;

  bl_dim_pwm u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .sync_in(sync_in), .pwm_out(pwm_out)
  );

  // ---------------- behavioural reference model ----------------
  int m_code [NCH];
  int m_thr  [NCH];
  bit m_full [NCH];
  bit m_master;
  int m_mask;
  int m_fcnt, m_per, m_meas, m_lockper;
  bit m_locked, m_prev;
  bit q1, q2, q3;

  function automatic int exp_high(input int code, input int p);
    int f;
    f = (p * 4) / 100;
    if (code == 255) return p;
    return f + (code * (p - f)) / 255;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin m_code[i] = 0; m_thr[i] = 0; m_full[i] = 0; end
      m_master = 0; m_mask = 0; m_fcnt = FREE - 1; m_per = FREE;
      m_meas = PMAX; m_lockper = PMAX; m_locked = 0; m_prev = 0;
      q1 = 0; q2 = 0; q3 = 0;
    end else begin
      bit edge_seen;
      int n;
      if (m_fcnt == m_per - 1) begin
        n = m_locked ? m_lockper : FREE;
        for (int i = 0; i < NCH; i++) begin
          m_full[i] = (m_code[i] == 255);
          m_thr[i]  = (n * 4) / 100 + (m_code[i] * (n - (n * 4) / 100)) / 255;
        end
        m_per = n; m_fcnt = 0;
      end else m_fcnt++;
      edge_seen = q2 && !q3;
      if (edge_seen) begin
        if (m_meas + 1 >= PMIN && m_meas + 1 <= PMAX) begin
          if (m_prev) begin m_locked = 1; m_lockper = m_meas + 1; end
          m_prev = 1;
        end else begin m_prev = 0; m_locked = 0; end
        m_meas = 0;
      end else if (m_meas == PMAX) begin
        m_prev = 0; m_locked = 0;
      end else m_meas++;
      q3 = q2; q2 = q1; q1 = sync_in;
      if (wr_valid) begin
        if (wr_addr == 8'h2B) m_master = wr_data[0];
        if (wr_addr == 8'h2C) m_mask = wr_data;
        if (wr_addr < 8'h08) m_code[wr_addr] = wr_data;
      end
    end
  end

  function automatic logic [7:0] model_out();
    logic [7:0] o;
    for (int i = 0; i < NCH; i++)
      o[i] = m_master && m_mask[i] && (m_full[i] || (m_fcnt < m_thr[i]));
    return o;
  endfunction

  // per-cycle comparison (R1 and every latency)
  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      checks++;
      if (pwm_out !== model_out()) begin
        errors++;
        $display("FAIL R1 cycle %0d pwm_out actual=%h expected=%h", cycles, pwm_out, model_out());
      end
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R1 watchdog actual=%0d cycles expected=completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // sync generator
  always @(negedge clk) begin
    if (sync_per > 0) begin
      sync_cnt = (sync_cnt + 1 >= sync_per) ? 0 : sync_cnt + 1;
      sync_in  = (sync_cnt < sync_per / 2);
    end else begin
      sync_cnt = 0;
      sync_in  = 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    check("R10 ready", int'(wr_ready), 1);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic find_start();
    logic prev;
    prev = pwm_out[0];
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (pwm_out[0] && !prev) return;
      prev = pwm_out[0];
    end
  endtask

  // counts high cycles of each channel over p cycles from a frame start;
  // optionally writes a code at cycle 50 of that frame
  task automatic count_frame(input int p, input int wch, input int wcode);
    find_start();
    for (int i = 0; i < NCH; i++) hc[i] = 0;
    for (int k = 0; k < p; k++) begin
      if (k > 0) @(negedge clk);
      for (int i = 0; i < NCH; i++) if (pwm_out[i]) hc[i]++;
      if (k == 50 && wch >= 0) begin
        wr_valid = 1'b1; wr_addr = 8'(wch); wr_data = 8'(wcode);
        @(negedge clk); k++;
        wr_valid = 1'b0;
        for (int i = 0; i < NCH; i++) if (pwm_out[i]) hc[i]++;
      end
    end
  endtask

  task automatic frame_len(output int n);
    logic prev;
    find_start();
    n = 0; prev = 1'b1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk); n++;
      if (pwm_out[0] && !prev) return;
      prev = pwm_out[0];
    end
  endtask

  int codes_init [NCH] = '{8'h00, 8'h7F, 8'hFF, 8'h40, 8'h80, 8'h10, 8'hE0, 8'h01};

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    check("R11 reset outputs low", int'(pwm_out), 0);

    for (int i = 0; i < NCH; i++) wr(8'(i), 8'(codes_init[i]));
    wr(8'h2C, 8'hFF);
    wr(8'h2B, 8'h01);
    repeat (FREE + 10) @(negedge clk);

    count_frame(FREE, -1, 0);
    check("R2 code 00 floor", hc[0], 16);
    check("R2 code 7F", hc[1], 207);
    check("R3 code FF full", hc[2], FREE);
    check("R2 code 40", hc[3], exp_high(8'h40, FREE));
    check("R1 ch6 independent", hc[6], exp_high(8'hE0, FREE));
    frame_len(n);
    check("R4 free-run period", n, FREE);

    count_frame(FREE, 3, 8'hC0);
    check("R9 old code holds this frame", hc[3], exp_high(8'h40, FREE));
    count_frame(FREE, -1, 0);
    check("R9 new code next frame", hc[3], exp_high(8'hC0, FREE));

    wr(8'h10, 8'h00);
    count_frame(FREE, -1, 0);
    check("R10 unmapped write ignored", hc[1], 207);

    wr(8'h2C, 8'hEF);
    check("R8 masked ch4 low", int'(pwm_out[4]), 0);
    count_frame(FREE, -1, 0);
    check("R8 masked ch4 frame", hc[4], 0);
    check("R8 other channel runs", hc[5], exp_high(8'h10, FREE));

    wr(8'h2B, 8'h00);
    check("R7 master off", int'(pwm_out), 0);
    repeat (FREE) @(negedge clk);
    wr(8'h2B, 8'h01);
    wr(8'h2C, 8'hFF);

    sync_per = 300;
    repeat (2000) @(negedge clk);
    frame_len(n);
    check("R5 lock 300", n, 300);
    count_frame(300, -1, 0);
    check("R2 floor at 300", hc[0], 12);

    sync_per = 500;
    repeat (3000) @(negedge clk);
    frame_len(n);
    check("R5 lock 500", n, 500);

    sync_per = 250;
    repeat (2500) @(negedge clk);
    frame_len(n);
    check("R6 out-of-window revert", n, FREE);

    sync_per = 320;
    repeat (2000) @(negedge clk);
    frame_len(n);
    check("R5 lock 320", n, 320);
    sync_per = 0;
    repeat (2000) @(negedge clk);
    frame_len(n);
    check("R6 timeout revert", n, FREE);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule